// File: doc/BRIEF.md
# Four-Entry Register Hardware Stack

This block is a small last-in, first-out store of four 16-bit words. It is built from its own registers and does not use the data memory. A processor control path uses it to save return addresses across subroutine calls and to pass arguments and results between a caller and a callee. A single push or a single pop completes in one clock cycle. The word on top of the stack is always visible on a combinational output, with no read strobe.

A 2-bit pointer always names the next free slot. It is modelled as a four-state machine:

- States: `SLOT_0`, `SLOT_1`, `SLOT_2` and `SLOT_3`.
- Transitions:
  - A push alone moves the pointer up one state: `SLOT_0`→`SLOT_1`→`SLOT_2`→`SLOT_3`→`SLOT_0`.
  - A pop alone moves it down one state: `SLOT_0`→`SLOT_3`→`SLOT_2`→`SLOT_1`→`SLOT_0`.
  - An idle cycle leaves the state unchanged.
  - A cycle with both push and pop asserted also leaves the state unchanged.

A push writes its data into the slot the pointer names. The top-of-stack output shows the slot one below the pointer. The pointer wraps in both directions and no error is signalled: a fifth push overwrites the oldest entry, and a pop of an empty stack reads stale or zero slots.

Top module: `hw_stack4`

## Requirements
- R1: During reset and right after it, the pointer is in `SLOT_0`, all four slots hold zero, and `top_o` reads zero.
- R2: A push with pop low stores `wr_data_i` into the slot at the pointer and advances the pointer by one. From the next cycle, `top_o` equals the pushed word.
- R3: A pop with push low moves the pointer down by one. From the next cycle, `top_o` shows the word pushed before the one removed.
- R4: With push and pop both low, the pointer and all slots keep their values, so `top_o` does not change.
- R5: Up to four pushes followed by pops return the words in reverse order of pushing.
- R6: With push and pop both high, the pointer holds and `wr_data_i` is still written into the slot at the pointer. `top_o` is unchanged, and the written word becomes visible after three further pops.
- R7: A push from `SLOT_3` moves the pointer to `SLOT_0`, so a fifth push overwrites the slot holding the oldest word.
- R8: A pop from `SLOT_0` moves the pointer to `SLOT_3`, after which `top_o` shows the slot at index 2.
- R9: Exactly one slot is write-enabled on a push cycle, and none on any other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Store `wr_data_i` and advance the pointer |
| pop_i | input | 1 | Remove the top word by moving the pointer down |
| wr_data_i | input | 16 | Word to be pushed |
| top_o | output | 16 | Word one slot below the pointer (current top) |

## Verification
The assertions assume that `push_i` and `pop_i` are never unknown once reset is released. They also assume that `wr_data_i` is settled by the clock edge where a push is sampled, because the write checks compare the slot with the past value of the data. The stimulus respects this by changing every input one nanosecond after a rising edge and by driving only defined 0/1 values. The pseudo-random sweep draws push, pop and data from a shift register, so all four push/pop combinations occur from every pointer state.

// File: rtl/hw_stack4_pkg.sv
package hw_stack4_pkg;

    localparam int STK_DEPTH = 4;
    localparam int PTR_W     = $clog2(STK_DEPTH);

    typedef enum logic [PTR_W-1:0] {
        SLOT_0 = 2'd0,
        SLOT_1 = 2'd1,
        SLOT_2 = 2'd2,
        SLOT_3 = 2'd3
    } slot_ptr_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } stk_op_e;

endpackage

// File: rtl/stk_ptr_fsm.sv
module stk_ptr_fsm
    import hw_stack4_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_i,
    input  logic                 pop_i,
    output logic [PTR_W-1:0]     ptr_o,
    output logic [STK_DEPTH-1:0] wr_en_o,
    output logic [PTR_W-1:0]     rd_sel_o
);

    slot_ptr_e state_q;
    slot_ptr_e state_d;
    stk_op_e   op;

    assign op = stk_op_e'({push_i, pop_i});

    // Next pointer: bit0 toggles either way; bit1 is XOR(up) or XNOR(down).
    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_PUSH: state_d = slot_ptr_e'({state_q[1] ^ state_q[0], ~state_q[0]});
            OP_POP:  state_d = slot_ptr_e'({~(state_q[1] ^ state_q[0]), ~state_q[0]});
            OP_IDLE: state_d = state_q;
            OP_BOTH: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_0;
        else        state_q <= state_d;
    end

    // Outputs: write decode gated by push; read select is pointer minus one.
    always_comb begin
        wr_en_o  = '0;
        rd_sel_o = {~(state_q[1] ^ state_q[0]), ~state_q[0]};
        unique case (state_q)
            SLOT_0: wr_en_o[0] = push_i;
            SLOT_1: wr_en_o[1] = push_i;
            SLOT_2: wr_en_o[2] = push_i;
            SLOT_3: wr_en_o[3] = push_i;
        endcase
    end

    assign ptr_o = state_q;

    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> (ptr_o == $past(ptr_o)));

    assert_ptr_both_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (ptr_o == $past(ptr_o)));

    assert_ptr_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (ptr_o == PTR_W'($past(ptr_o) + 2'd1)));

    assert_ptr_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (ptr_o == PTR_W'($past(ptr_o) - 2'd1)));

    assert_one_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> ($countones(wr_en_o) == 1));

    assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !push_i |-> (wr_en_o == '0));

endmodule

// File: rtl/stk_slot_bank.sv
module stk_slot_bank #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEPTH-1:0]              wr_en_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    output logic [DEPTH-1:0][DATA_W-1:0]  slots_o
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)          slots_o[g] <= '0;
            else if (wr_en_i[g]) slots_o[g] <= wr_data_i;
        end

        assert_slot_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en_i[g] |=> $stable(slots_o[g]));

        assert_slot_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i[g] |=> (slots_o[g] == $past(wr_data_i)));
    end

endmodule

// File: rtl/stk_top_sel.sv
module stk_top_sel #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic [DEPTH-1:0][DATA_W-1:0] slots_i,
    input  logic [1:0]                   sel_i,
    output logic [DATA_W-1:0]            top_o
);

    localparam int PAIRS = DEPTH / 2;

    logic [PAIRS-1:0][DATA_W-1:0] lvl1;

    // First level: low select bit picks within each pair of slots.
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign lvl1[k] = sel_i[0] ? slots_i[2*k+1] : slots_i[2*k];
    end

    // Second level: high select bit picks the pair.
    assign top_o = sel_i[1] ? lvl1[1] : lvl1[0];

endmodule

// File: rtl/hw_stack4.sv
module hw_stack4
    import hw_stack4_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] top_o
);

    logic [PTR_W-1:0]                  ptr;
    logic [STK_DEPTH-1:0]              wr_en;
    logic [PTR_W-1:0]                  rd_sel;
    logic [STK_DEPTH-1:0][DATA_W-1:0]  slots;

    stk_ptr_fsm u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .ptr_o    (ptr),
        .wr_en_o  (wr_en),
        .rd_sel_o (rd_sel)
    );

    stk_slot_bank #(.DATA_W(DATA_W), .DEPTH(STK_DEPTH)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data_i),
        .slots_o   (slots)
    );

    stk_top_sel #(.DATA_W(DATA_W), .DEPTH(STK_DEPTH)) u_sel (
        .slots_i (slots),
        .sel_i   (rd_sel),
        .top_o   (top_o)
    );

    assert_push_shows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (top_o == $past(wr_data_i)));

    assert_both_top_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(top_o));

    assert_idle_top_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(top_o));

    assert_reset_ptr_R1: assert property (@(posedge clk)
        !rst_n |=> (ptr == '0));

endmodule

// File: tb/hw_stack4_tb.sv
module hw_stack4_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] top_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [15:0] mdl [4];
    int          mptr = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    hw_stack4 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .wr_data_i (wr_data_i),
        .top_o     (top_o)
    );

    task automatic check(input string req, input logic [15:0] exp);
        tests++;
        if (top_o !== exp) begin
            fails++;
            $display("FAIL %s: top_o=%h expected %h", req, top_o, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        push_i = 1'b0;
        pop_i  = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        mptr = 0;
    endtask

    // Drive one cycle, then update the model and compare after the edge.
    task automatic step(input bit p, input bit q, input logic [15:0] d, input string req);
        push_i    = p;
        pop_i     = q;
        wr_data_i = d;
        @(posedge clk);
        #1;
        if (p) mdl[mptr] = d;
        if (p && !q) mptr = (mptr + 1) % 4;
        if (q && !p) mptr = (mptr + 3) % 4;
        push_i = 1'b0;
        pop_i  = 1'b0;
        check(req, mdl[(mptr + 3) % 4]);
    endtask

    initial begin
        #100000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: top_o=%h expected completion", top_o);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1", 16'h0000);
        step(0, 1, 16'h0, "R8");      // pointer 0 -> 3, reads zeroed slot 2
        step(0, 1, 16'h0, "R1");      // zeroed slots everywhere
        step(0, 0, 16'h0, "R4");

        do_reset();
        step(1, 0, 16'h1111, "R2");
        step(1, 0, 16'h2222, "R2");
        step(1, 0, 16'h3333, "R2");
        step(1, 0, 16'h4444, "R2");
        step(0, 0, 16'hFFFF, "R4");
        step(0, 1, 16'h0, "R5");
        step(0, 1, 16'h0, "R5");
        step(0, 1, 16'h0, "R3");
        step(0, 1, 16'h0, "R8");      // pointer 0 -> 3

        do_reset();
        for (int i = 0; i < 5; i++) step(1, 0, 16'hA000 + 16'(i), "R7");
        for (int i = 0; i < 4; i++) step(0, 1, 16'h0, "R7");

        do_reset();
        step(1, 0, 16'h0B0B, "R2");
        step(1, 1, 16'h5A5A, "R6");   // top unchanged
        step(0, 1, 16'h0, "R6");
        step(0, 1, 16'h0, "R6");
        step(0, 1, 16'h0, "R6");      // written word now on top
        if (top_o !== 16'h5A5A) begin
            fails++;
            $display("FAIL R6: top_o=%h expected %h", top_o, 16'h5A5A);
        end
        tests++;

        do_reset();
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[1:0] == 2'b10)      step(1, 0, lfsr, "R2");
            else if (lfsr[1:0] == 2'b01) step(0, 1, lfsr, "R3");
            else if (lfsr[1:0] == 2'b11) step(1, 1, lfsr, "R6");
            else                         step(0, 0, lfsr, "R4");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule